// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between the PWM modulator and the gate drivers of a synchronous buck stage. It turns a one-bit PWM request into two registered gate enables, one for the high-side switch and one for the low-side switch. It is built so that the two switches are never commanded on together. The dead time between them is not a fixed delay. Each turn-on waits for a sensed sign that the other switch has really turned off. Before the low side turns on, the switch-node-low comparator must report that the node has fallen. Before the high side turns on, the low-gate-low comparator must report that the low-side gate has discharged.

When the inductor current is negative, the switch node may never fall after the high side turns off. For that case a watchdog counts the cycles spent waiting. When the count runs out, it turns the low side on anyway, so that the current can recirculate. High-side on-time is capped at a fraction of the switching period.

Two overrides from the protection logic take precedence over the PWM request. The first forces both switches off. The second forces the low side on and the high side off. A low-side mask from the startup logic stops normal low-side turn-on, which matters when starting into a pre-biased output. The low-side override is not affected by this mask.

Top module: `deadtime_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, both gate enables are low.
- R2: The high-side and low-side enables are never high in the same clock cycle.
- R3: When the high side has turned off, the low side turns on at the clock edge after the first cycle in which the switch-node-low flag is sampled high. This gives at least one cycle with both enables low.
- R4: The high side turns on only at a clock edge where, in the cycle before, the low-gate-low flag was high and the low-side enable was low. While the flag stays low, a pending request waits.
- R5: If the switch-node-low flag stays low after high-side turn-off, the low side turns on after exactly WDOG_CYCLES cycles with both enables low.
- R6: The high side stays on for at most MAX_ON = floor(CLK_HZ/SW_HZ × DUTY_PCT/100) consecutive cycles. After that cut, it stays off until the PWM request has been low for at least one cycle.
- R7: A high force-off input drives both enables low at the next clock edge. It overrides every other input, including force-low-side.
- R8: A high force-low-side input, with force-off low, drives the high side low at the next edge. If the high side was on, the low side turns on one edge later; otherwise it turns on at the next edge. The low-side mask and the PWM request do not affect it.
- R9: While the low-side mask is high and no override is active, the low-side enable does not rise. A low-side enable that is already high falls at the next edge.
- R10: When the PWM request is low, the high-side enable is low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_req | input | 1 | PWM request; high asks for high-side conduction |
| sw_node_low | input | 1 | Comparator flag: switch node has fallen |
| lo_gate_low | input | 1 | Comparator flag: low-side gate has discharged |
| ls_mask | input | 1 | Startup mask suppressing normal low-side turn-on |
| force_off | input | 1 | Protection override: both switches off |
| force_ls | input | 1 | Protection override: low side on, high side off |
| hs_en | output | 1 | Registered high-side gate enable |
| ls_en | output | 1 | Registered low-side gate enable |

## Verification
The bench builds the block with CLK_HZ = 3 MHz, SW_HZ = 300 kHz and DUTY_PCT = 80, which gives a ten-cycle period and an on-time cap of eight cycles. It also uses WDOG_CYCLES = 5. With these values, a request held high for a few dozen cycles is enough to reach the on-time cap and the blocked state that follows it. A switch-node flag held low runs the watchdog to expiry within a short directed sequence. This lets the random phase hit both limits many times, mixed with overrides and mask toggles.

// File: rtl/deadtime_pkg.sv
package deadtime_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_HIGH   = 2'd1,
    PH_SETTLE = 2'd2,
    PH_LOW    = 2'd3
  } phase_t;
endpackage

// File: rtl/ontime_limiter.sv
module ontime_limiter #(
  parameter int MAX_ON = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_req,
  input  logic hs_en,
  output logic pwm_ok
);
  localparam int OCW = (MAX_ON < 2) ? 1 : $clog2(MAX_ON + 1);

  logic [OCW-1:0] on_cnt;
  logic           blocked;
  logic           last_cyc;

  assign last_cyc = hs_en && (on_cnt == OCW'(MAX_ON - 1));
  assign pwm_ok   = pwm_req && !blocked && !last_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_cnt  <= '0;
      blocked <= 1'b0;
    end else begin
      on_cnt <= hs_en ? on_cnt + 1'b1 : '0;
      if (!pwm_req)
        blocked <= 1'b0;
      else if (last_cyc)
        blocked <= 1'b1;
    end
  end

  // on-time cap: the last permitted high-side cycle is followed by turn-off
  assert_on_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (hs_en && on_cnt == OCW'(MAX_ON - 1)) |=> !hs_en);
endmodule

// File: rtl/settle_watchdog.sv
module settle_watchdog #(
  parameter int WDOG_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);
  localparam int WCW = (WDOG_CYCLES < 2) ? 1 : $clog2(WDOG_CYCLES + 1);
  localparam logic [WCW-1:0] LAST = WCW'(WDOG_CYCLES - 1);

  logic [WCW-1:0] cnt;

  assign expired = arm && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!arm)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gate_phase_fsm.sv
module gate_phase_fsm
  import deadtime_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pwm_ok,
  input  logic sw_node_low,
  input  logic lo_gate_low,
  input  logic ls_mask,
  input  logic force_off,
  input  logic force_ls,
  input  logic wd_expired,
  output logic settle_arm,
  output logic hs_en,
  output logic ls_en
);
  phase_t st, st_nx;
  logic   hs_nx, ls_nx;

  assign settle_arm = (st == PH_SETTLE);

  always_comb begin
    st_nx = st;
    hs_nx = 1'b0;
    ls_nx = 1'b0;
    if (force_off) begin
      st_nx = PH_IDLE;
    end else if (force_ls) begin
      if (st == PH_HIGH) begin
        st_nx = PH_SETTLE;
      end else begin
        st_nx = PH_LOW;
        ls_nx = 1'b1;
      end
    end else begin
      unique case (st)
        PH_IDLE: begin
          if (pwm_ok) begin
            if (lo_gate_low) begin
              st_nx = PH_HIGH;
              hs_nx = 1'b1;
            end
          end else if (!ls_mask) begin
            st_nx = PH_SETTLE;
          end
        end
        PH_HIGH: begin
          if (pwm_ok) hs_nx = 1'b1;
          else        st_nx = PH_SETTLE;
        end
        PH_SETTLE: begin
          if (ls_mask) begin
            st_nx = PH_IDLE;
          end else if (sw_node_low || wd_expired) begin
            st_nx = PH_LOW;
            ls_nx = 1'b1;
          end
        end
        PH_LOW: begin
          if (pwm_ok || ls_mask) st_nx = PH_IDLE;
          else                   ls_nx = 1'b1;
        end
        default: st_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PH_IDLE;
      hs_en <= 1'b0;
      ls_en <= 1'b0;
    end else begin
      st    <= st_nx;
      hs_en <= hs_nx;
      ls_en <= ls_nx;
    end
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  assert_ls_after_sense_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> ($past(force_ls) || $past(sw_node_low) || $past(wd_expired)));

  assert_hs_after_lg_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> ($past(lo_gate_low) && !$past(ls_en)));

  assert_force_off_R7: assert property (@(posedge clk) disable iff (rst)
    force_off |=> (!hs_en && !ls_en));

  assert_force_ls_R8: assert property (@(posedge clk) disable iff (rst)
    (force_ls && !force_off) |=> !hs_en);

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ls_mask && !force_ls && !force_off) |=> !ls_en);
endmodule

// File: rtl/deadtime_sequencer.sv
module deadtime_sequencer #(
  parameter int CLK_HZ      = 250_000_000,
  parameter int SW_HZ       = 300_000,
  parameter int DUTY_PCT    = 80,
  parameter int WDOG_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_req,
  input  logic sw_node_low,
  input  logic lo_gate_low,
  input  logic ls_mask,
  input  logic force_off,
  input  logic force_ls,
  output logic hs_en,
  output logic ls_en
);
  localparam int PERIOD = CLK_HZ / SW_HZ;
  localparam int MAX_ON = (PERIOD * DUTY_PCT) / 100;

  logic pwm_ok;
  logic settle_arm;
  logic wd_expired;

  ontime_limiter #(.MAX_ON(MAX_ON)) u_limit (
    .clk     (clk),
    .rst     (rst),
    .pwm_req (pwm_req),
    .hs_en   (hs_en),
    .pwm_ok  (pwm_ok)
  );

  settle_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .arm     (settle_arm),
    .expired (wd_expired)
  );

  gate_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pwm_ok      (pwm_ok),
    .sw_node_low (sw_node_low),
    .lo_gate_low (lo_gate_low),
    .ls_mask     (ls_mask),
    .force_off   (force_off),
    .force_ls    (force_ls),
    .wd_expired  (wd_expired),
    .settle_arm  (settle_arm),
    .hs_en       (hs_en),
    .ls_en       (ls_en)
  );

  assert_pwm_low_R10: assert property (@(posedge clk) disable iff (rst)
    !pwm_req |=> !hs_en);
endmodule

// File: tb/test_deadtime_sequencer.sv
module test_deadtime_sequencer;
  localparam int CLK_HZ = 3_000_000;
  localparam int SW_HZ  = 300_000;
  localparam int DUTY   = 80;
  localparam int WD     = 5;
  localparam int MAXON  = ((CLK_HZ / SW_HZ) * DUTY) / 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_req = 0, sw_node_low = 0, lo_gate_low = 0;
  logic ls_mask = 0, force_off = 0, force_ls = 0;
  logic hs_en, ls_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_st = 0;   // 0 idle, 1 high, 2 settle, 3 low
  int m_on = 0, m_wd = 0;
  bit m_blk = 0, m_hs = 0, m_ls = 0;

  always #2 clk = ~clk;

  deadtime_sequencer #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .DUTY_PCT(DUTY),
                       .WDOG_CYCLES(WD)) i_deadtime_sequencer (
    .clk(clk), .rst(rst), .pwm_req(pwm_req), .sw_node_low(sw_node_low),
    .lo_gate_low(lo_gate_low), .ls_mask(ls_mask), .force_off(force_off),
    .force_ls(force_ls), .hs_en(hs_en), .ls_en(ls_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    bit last, pok, wexp, n_blk, n_hs, n_ls;
    int n_st, n_on, n_wd;
    last = m_hs && (m_on == MAXON - 1);
    pok  = pwm_req && !m_blk && !last;
    wexp = (m_st == 2) && (m_wd == WD - 1);
    n_blk = !pwm_req ? 1'b0 : (last ? 1'b1 : m_blk);
    n_on  = m_hs ? m_on + 1 : 0;
    n_wd  = (m_st == 2) ? ((m_wd == WD - 1) ? m_wd : m_wd + 1) : 0;
    n_st = m_st; n_hs = 0; n_ls = 0;
    if (force_off) n_st = 0;
    else if (force_ls) begin
      if (m_st == 1) n_st = 2;
      else begin n_st = 3; n_ls = 1; end
    end else begin
      case (m_st)
        0: if (pok) begin
             if (lo_gate_low) begin n_st = 1; n_hs = 1; end
           end else if (!ls_mask) n_st = 2;
        1: if (pok) n_hs = 1; else n_st = 2;
        2: if (ls_mask) n_st = 0;
           else if (sw_node_low || wexp) begin n_st = 3; n_ls = 1; end
        default: if (pok || ls_mask) n_st = 0; else n_ls = 1;
      endcase
    end
    @(posedge clk);
    #1;
    if (rst) begin
      m_st = 0; m_on = 0; m_wd = 0; m_blk = 0; m_hs = 0; m_ls = 0;
    end else begin
      m_st = n_st; m_on = n_on; m_wd = n_wd; m_blk = n_blk; m_hs = n_hs; m_ls = n_ls;
    end
    chk({tag, " hs"}, int'(hs_en), int'(m_hs));
    chk({tag, " ls"}, int'(ls_en), int'(m_ls));
    chk("R2 overlap", int'(hs_en && ls_en), 0);
  endtask

  task automatic set_in(input bit p, input bit s, input bit g, input bit m,
                        input bit fo, input bit fl);
    pwm_req = p; sw_node_low = s; lo_gate_low = g; ls_mask = m;
    force_off = fo; force_ls = fl;
  endtask

  task automatic do_reset();
    set_in(0, 0, 0, 0, 0, 0);
    rst = 1;
    cycle("R1 rst");
    cycle("R1 rst");
    chk("R1 hs in reset", int'(hs_en), 0);
    chk("R1 ls in reset", int'(ls_en), 0);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int run, gap;
    void'($urandom(32'd24680));
    #1;
    do_reset();
    cycle("R1 first");
    chk("R1 hs after reset", int'(hs_en), 0);
    chk("R1 ls after reset", int'(ls_en), 0);

    // R10: request drop ends high side
    do_reset();
    set_in(1, 1, 1, 0, 0, 0); cycle("R10 on");
    chk("R10 hs rises", int'(hs_en), 1);
    pwm_req = 0; cycle("R10 off");
    chk("R10 hs falls", int'(hs_en), 0);

    // R3: sensed switch node gives one dead cycle
    do_reset();
    set_in(1, 1, 1, 0, 0, 0); cycle("R3 on");
    pwm_req = 0; cycle("R3 off");
    gap = 0;
    for (int i = 0; i < 20 && !ls_en; i++) begin
      if (!hs_en && !ls_en) gap++;
      cycle("R3 wait");
    end
    chk("R3 dead cycles", gap, 1);
    chk("R3 ls on", int'(ls_en), 1);

    // R5: switch node never falls, watchdog turns low side on
    do_reset();
    set_in(1, 0, 1, 0, 0, 0); cycle("R5 on");
    pwm_req = 0; cycle("R5 off");
    gap = 0;
    for (int i = 0; i < 40 && !ls_en; i++) begin
      if (!hs_en && !ls_en) gap++;
      cycle("R5 wait");
    end
    chk("R5 watchdog cycles", gap, WD);
    chk("R5 ls on", int'(ls_en), 1);

    // R4: low-gate flag gates high-side turn-on
    do_reset();
    set_in(0, 1, 1, 0, 0, 0);
    cycle("R4 a"); cycle("R4 b");
    chk("R4 ls on first", int'(ls_en), 1);
    set_in(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cycle("R4 hold");
    chk("R4 hs waits", int'(hs_en), 0);
    chk("R4 ls off", int'(ls_en), 0);
    lo_gate_low = 1; cycle("R4 go");
    chk("R4 hs rises", int'(hs_en), 1);

    // R6: on-time cap and block until request low
    do_reset();
    set_in(1, 1, 1, 0, 0, 0);
    run = 0;
    for (int i = 0; i < 30; i++) begin
      cycle("R6 hold");
      if (hs_en) run++;
    end
    chk("R6 capped run", run, MAXON);
    chk("R6 still blocked", int'(hs_en), 0);
    pwm_req = 0; cycle("R6 release");
    pwm_req = 1; cycle("R6 ls off"); cycle("R6 again");
    chk("R6 resumes", int'(hs_en), 1);

    // R7: force-off beats everything
    do_reset();
    set_in(1, 1, 1, 0, 0, 0); cycle("R7 on");
    force_off = 1; force_ls = 1; cycle("R7 force");
    chk("R7 hs", int'(hs_en), 0);
    chk("R7 ls", int'(ls_en), 0);

    // R8: force low side from high side, mask ignored
    do_reset();
    set_in(1, 0, 1, 0, 0, 0); cycle("R8 on");
    ls_mask = 1; force_ls = 1; cycle("R8 dead");
    chk("R8 hs off", int'(hs_en), 0);
    chk("R8 ls dead", int'(ls_en), 0);
    cycle("R8 ls");
    chk("R8 ls on", int'(ls_en), 1);

    // R9: mask holds low side off and drops it
    do_reset();
    set_in(0, 1, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) cycle("R9 hold");
    chk("R9 ls masked", int'(ls_en), 0);
    ls_mask = 0; cycle("R9 a"); cycle("R9 b");
    chk("R9 ls on", int'(ls_en), 1);
    ls_mask = 1; cycle("R9 drop");
    chk("R9 ls dropped", int'(ls_en), 0);

    // random phase against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) pwm_req = ~pwm_req;
      sw_node_low = ($urandom_range(0, 9) < 6);
      lo_gate_low = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 39) == 0) ls_mask = ~ls_mask;
      force_off = ($urandom_range(0, 49) == 0);
      force_ls  = ($urandom_range(0, 29) == 0);
      cycle("R3 R4 R5 R6 R8 R9 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule